// File: doc/BRIEF.md
# Supply Threshold Supervisor

This block turns three digital supply-comparator flags into the actions a processor needs as its supply sags and recovers. The flags are ordered: one says the supply is below the early-warning level, one that it is below the lowest level at which code may run, and one that it is below the level at which the backup cell must take over. Each flag passes through a synchronizer and a persistence filter. The filtered flags then drive a four-state sequencer whose states are ordered run, warn, hold and battery. It only ever steps to a neighbouring state.

In the warn state, the processor keeps running and can receive one interrupt request that carries a fixed vector. In hold, the processor is held in reset and the memory chip enables and the read/write strobe are forced to their inactive level. In battery, the backup cell is selected as well. The sequencer leaves hold toward run only after the minimum-level flag has stayed clear for a fixed number of oscillator cycles. The same delay applies after a cold reset, so it also acts as the power-on delay.

Top module: `power_fail_supervisor`

## Requirements
- R1: A change on any comparator flag that lasts fewer than FILT_CYCLES clock cycles has no effect on any output. A change that lasts FILT_CYCLES cycles or more is acted on.
- R2: While not in reset, when the filtered warning flag rises and `warn_ie` is 1, `warn_irq` is high for exactly one cycle. `irq_vector` reads IRQ_VECTOR, which defaults to 8'h2B. `cpu_reset` stays 0 in the warn state.
- R3: While the warning flag stays high, only one interrupt is produced. A second one needs the flag to fall and rise again.
- R4: With `warn_ie` at 0, a rising warning flag produces no interrupt, and that crossing is consumed.
- R5: When the minimum-level flag is set, `cpu_reset` and `strobe_gate` are both 1.
- R6: When the battery-level flag is set, `batt_sel` is 1, and `cpu_reset` and `strobe_gate` stay 1. The battery state is entered only from hold.
- R7: `cpu_reset` falls only after both the minimum-level and battery-level flags have been clear for POR_CYCLES consecutive cycles in the hold state.
- R8: During and right after a cold reset, `cpu_reset` and `strobe_gate` are 1, and `batt_sel` and `warn_irq` are 0. Release follows the R7 delay once the supply is good.
- R9: The state changes by at most one step per cycle. Leaving battery therefore passes through hold and pays the full R7 delay.
- R10: No interrupt is produced while in hold or battery, or on the way out of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low |
| below_warn | input | 1 | Supply below the warning level |
| below_min | input | 1 | Supply below the minimum operating level |
| below_batt | input | 1 | Supply below the backup switchover level |
| warn_ie | input | 1 | Warning interrupt enable |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| irq_vector | output | VEC_W | Vector address for the warning interrupt |
| cpu_reset | output | 1 | Processor reset, active high |
| strobe_gate | output | 1 | 1 forces chip enables and read/write strobe inactive |
| batt_sel | output | 1 | 1 selects the backup cell |

## Verification
The bench sweeps every combination of the three flags, with the interrupt enable both on and off. For each it computes the expected level as the highest flag set. A sequencer that jumped states, or that skipped hold on the way out of battery, would drop reset early. The bench catches this by sampling reset one full delay after the flags clear. Glitches of every length below the filter depth are applied and must leave reset low; a filter that is too short would pulse reset. The bench also covers a warning held for a long time, a warning that rises while in reset, and the recovery path with the warning still set. These tests catch a design that fires again without rearming, or one that leaks an interrupt out of reset.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_WARN = 2'd1,
      PS_HOLD = 2'd2,
      PS_BATT = 2'd3
   } pwr_state_e;

   localparam int N_FLAGS   = 3;
   localparam int FLAG_WARN = 0;
   localparam int FLAG_MIN  = 1;
   localparam int FLAG_BATT = 2;
endpackage

// File: rtl/pfs_flag_filter.sv
// Synchronizer followed by a persistence filter: the clean output takes a new
// value only after the synchronized input has held it for HOLD_CYCLES cycles.
module pfs_flag_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4,
   parameter bit INIT        = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pfs_flag_filter: SYNC_STAGES must be at least 2");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("pfs_flag_filter: HOLD_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   clean_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{INIT}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (HOLD_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clean_q <= INIT;
         else        clean_q <= synced;
      end
   end else begin : g_count
      localparam int            CW   = $clog2(HOLD_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q   <= '0;
            clean_q <= INIT;
         end else if (synced == clean_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            clean_q <= synced;
            run_q   <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign clean_o = clean_q;
endmodule

// File: rtl/pfs_por_timer.sv
// Counts consecutive cycles of run_i; done_o is high on the last one.
module pfs_por_timer #(
   parameter int POR_CYCLES = 21504
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   if (POR_CYCLES < 2) begin : g_bad_por
      $error("pfs_por_timer: POR_CYCLES must be at least 2");
   end

   localparam int            CW   = $clog2(POR_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pfs_state_seq.sv
// Ordered supply state: steps one level per cycle toward the highest set flag;
// stepping down out of hold waits for the delay timer.
module pfs_state_seq
   import pfs_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] lvl_i,
   input  logic               por_done_i,
   output pwr_state_e         state_o
);
   pwr_state_e state_q, state_d, goal;
   logic [1:0] step_up, step_dn;

   always_comb begin
      if (lvl_i[FLAG_BATT])      goal = PS_BATT;
      else if (lvl_i[FLAG_MIN])  goal = PS_HOLD;
      else if (lvl_i[FLAG_WARN]) goal = PS_WARN;
      else                       goal = PS_RUN;
   end

   assign step_up = state_q + 2'd1;
   assign step_dn = state_q - 2'd1;

   always_comb begin
      state_d = state_q;
      if (goal > state_q) begin
         state_d = pwr_state_e'(step_up);
      end else if (goal < state_q) begin
         if (state_q != PS_HOLD || por_done_i) state_d = pwr_state_e'(step_dn);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_HOLD;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/power_fail_supervisor.sv
module power_fail_supervisor
   import pfs_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter int               FILT_CYCLES = 4,
   parameter int               POR_CYCLES  = 21504,
   parameter int               VEC_W       = 8,
   parameter logic [VEC_W-1:0] IRQ_VECTOR  = 'h2B
) (
   input  logic             clk,
   input  logic             cold_rst_n,
   input  logic             below_warn,
   input  logic             below_min,
   input  logic             below_batt,
   input  logic             warn_ie,
   output logic             warn_irq,
   output logic [VEC_W-1:0] irq_vector,
   output logic             cpu_reset,
   output logic             strobe_gate,
   output logic             batt_sel
);
   if (VEC_W < 1) begin : g_bad_vec
      $error("power_fail_supervisor: VEC_W must be positive");
   end

   // After cold reset the supply is assumed below warn and min, above batt.
   localparam logic [N_FLAGS-1:0] FLAG_INIT = 3'b011;

   logic [N_FLAGS-1:0] raw_flags, clean;
   pwr_state_e         state_q;
   logic               por_run, por_done;
   logic               warn_seen_q, irq_q, in_reset;

   assign raw_flags = {below_batt, below_min, below_warn};

   for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
      pfs_flag_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .HOLD_CYCLES (FILT_CYCLES),
         .INIT        (FLAG_INIT[g])
      ) u_filt (
         .clk     (clk),
         .rst_n   (cold_rst_n),
         .raw_i   (raw_flags[g]),
         .clean_o (clean[g])
      );
   end

   assign por_run = (state_q == PS_HOLD) && !clean[FLAG_MIN] && !clean[FLAG_BATT];

   pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk    (clk),
      .rst_n  (cold_rst_n),
      .run_i  (por_run),
      .done_o (por_done)
   );

   pfs_state_seq u_seq (
      .clk        (clk),
      .rst_n      (cold_rst_n),
      .lvl_i      (clean),
      .por_done_i (por_done),
      .state_o    (state_q)
   );

   assign in_reset = (state_q == PS_HOLD) || (state_q == PS_BATT);

   // Edge detect on the filtered warning flag; reset value 1 means the
   // flag must be seen low before the first request can fire.
   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         warn_seen_q <= 1'b1;
         irq_q       <= 1'b0;
      end else begin
         warn_seen_q <= clean[FLAG_WARN];
         irq_q       <= clean[FLAG_WARN] && !warn_seen_q && warn_ie && !in_reset;
      end
   end

   assign warn_irq    = irq_q;
   assign irq_vector  = IRQ_VECTOR;
   assign cpu_reset   = in_reset;
   assign strobe_gate = in_reset;
   assign batt_sel    = (state_q == PS_BATT);
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker (
   input logic       clk,
   input logic       cold_rst_n,
   input logic       warn_irq,
   input logic       warn_ie,
   input logic       cpu_reset,
   input logic       batt_sel,
   input logic [1:0] state_q,
   input logic       por_done
);
   logic [2:0] st_w;
   assign st_w = {1'b0, state_q};

   p_step_adjacent_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (st_w == $past(st_w)) || (st_w == $past(st_w) + 3'd1) || (st_w + 3'd1 == $past(st_w)));

   p_irq_single_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
      warn_irq |=> !warn_irq);

   p_irq_enable_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
      warn_irq |-> $past(warn_ie));

   p_irq_quiet_in_reset_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
      warn_irq |-> !$past(cpu_reset));

   p_por_release_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $fell(cpu_reset) |-> $past(por_done));

   p_batt_via_reset_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $rose(batt_sel) |-> $past(cpu_reset));
endmodule

bind power_fail_supervisor pfs_checker u_pfs_checker (
   .clk        (clk),
   .cold_rst_n (cold_rst_n),
   .warn_irq   (warn_irq),
   .warn_ie    (warn_ie),
   .cpu_reset  (cpu_reset),
   .batt_sel   (batt_sel),
   .state_q    (state_q),
   .por_done   (por_done)
);

// File: tb/tb_power_fail_supervisor.sv
module tb_power_fail_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int FILT       = 4;
   localparam int POR        = 64;
   localparam int SETTLE     = FILT + 12;

   logic       clk = 1'b0;
   logic       cold_rst_n = 1'b0;
   logic       below_warn = 1'b1, below_min = 1'b1, below_batt = 1'b0, warn_ie = 1'b1;
   logic       warn_irq, cpu_reset, strobe_gate, batt_sel;
   logic [7:0] irq_vector;

   int total = 0;
   int bad   = 0;
   int irq_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   power_fail_supervisor #(
      .SYNC_STAGES (2),
      .FILT_CYCLES (FILT),
      .POR_CYCLES  (POR),
      .VEC_W       (8),
      .IRQ_VECTOR  (8'h2B)
   ) dut (
      .clk         (clk),
      .cold_rst_n  (cold_rst_n),
      .below_warn  (below_warn),
      .below_min   (below_min),
      .below_batt  (below_batt),
      .warn_ie     (warn_ie),
      .warn_irq    (warn_irq),
      .irq_vector  (irq_vector),
      .cpu_reset   (cpu_reset),
      .strobe_gate (strobe_gate),
      .batt_sel    (batt_sel)
   );

   // Every cycle with the request high counts; a wide pulse shows as extra.
   always @(posedge clk) if (cold_rst_n && warn_irq) irq_cnt <= irq_cnt + 1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int base;
      // R8: state held during cold reset
      tick(5);
      chk("R8 reset cpu_reset", cpu_reset, 1);
      chk("R8 reset strobe_gate", strobe_gate, 1);
      chk("R8 reset batt_sel", batt_sel, 0);
      chk("R8 reset warn_irq", warn_irq, 0);
      cold_rst_n = 1'b1;
      below_warn = 1'b0; below_min = 1'b0;
      tick(POR);
      chk("R8 power-on delay still in reset", cpu_reset, 1);
      tick(SETTLE);
      chk("R8 power-on release", cpu_reset, 0);
      chk("R8 strobe released", strobe_gate, 0);
      chk("R10 no irq on power-on", irq_cnt, 0);
      chk("R2 vector value", irq_vector, 8'h2B);

      // R1: glitches shorter than the filter depth
      for (int len = 1; len < FILT; len++) begin
         base = irq_cnt;
         below_min = 1'b1; tick(len); below_min = 1'b0;
         tick(SETTLE);
         chk("R1 min glitch ignored", cpu_reset, 0);
         below_warn = 1'b1; tick(len); below_warn = 1'b0;
         tick(SETTLE);
         chk("R1 warn glitch ignored", irq_cnt - base, 0);
         below_batt = 1'b1; tick(len); below_batt = 1'b0;
         tick(SETTLE);
         chk("R1 batt glitch ignored", batt_sel, 0);
      end

      // Sweep all flag combinations with enable on and off (R2 R4 R5 R6 R7 R9)
      for (int ie = 0; ie < 2; ie++) begin
         for (int combo = 1; combo < 8; combo++) begin
            int lvl;
            int w, m, b;
            w = combo & 1; m = (combo >> 1) & 1; b = (combo >> 2) & 1;
            lvl = b ? 3 : (m ? 2 : (w ? 1 : 0));
            base = irq_cnt;
            warn_ie = ie[0];
            below_warn = w[0]; below_min = m[0]; below_batt = b[0];
            tick(SETTLE);
            chk("R5 cpu_reset by level", cpu_reset, (lvl >= 2) ? 1 : 0);
            chk("R5 strobe_gate by level", strobe_gate, (lvl >= 2) ? 1 : 0);
            chk("R6 batt_sel by level", batt_sel, (lvl == 3) ? 1 : 0);
            chk("R2 R4 irq count", irq_cnt - base, w * ie);
            below_warn = 1'b0; below_min = 1'b0; below_batt = 1'b0;
            if (lvl >= 2) begin
               tick(POR);
               chk(b ? "R9 battery exit pays delay" : "R7 delay holds reset", cpu_reset, 1);
            end
            tick(SETTLE);
            chk("R7 released after delay", cpu_reset, 0);
            chk("R6 batt_sel cleared", batt_sel, 0);
            chk("R10 no irq on recovery", irq_cnt - base, w * ie);
         end
      end
      warn_ie = 1'b1;

      // R3: one request per crossing, rearm after deassert
      base = irq_cnt;
      below_warn = 1'b1;
      tick(200);
      chk("R3 single irq while held", irq_cnt - base, 1);
      chk("R2 no reset in warn", cpu_reset, 0);
      below_warn = 1'b0; tick(SETTLE);
      below_warn = 1'b1; tick(SETTLE);
      chk("R3 rearmed after deassert", irq_cnt - base, 2);
      below_warn = 1'b0; tick(SETTLE);

      // R4: crossing with enable low is consumed
      base = irq_cnt;
      warn_ie = 1'b0; below_warn = 1'b1; tick(SETTLE);
      warn_ie = 1'b1; tick(SETTLE);
      chk("R4 disabled crossing consumed", irq_cnt - base, 0);
      below_warn = 1'b0; tick(SETTLE);

      // R10: warning rising while in reset, recovery with warning still set
      base = irq_cnt;
      below_min = 1'b1; tick(SETTLE);
      below_warn = 1'b1; tick(SETTLE);
      chk("R10 no irq in reset", irq_cnt - base, 0);
      below_min = 1'b0;
      tick(POR + SETTLE);
      chk("R10 recovered to warn", cpu_reset, 0);
      chk("R10 no irq leaving reset", irq_cnt - base, 0);
      below_warn = 1'b0; tick(SETTLE);

      summary();
      $finish;
   end
endmodule